// File: doc/BRIEF.md
# Programmable Interrupt Controller Channel

This block arbitrates eight interrupt request lines for a processor. Each line is latched into a request register, either on a rising level (edge mode) or by following the line directly (level mode), as chosen by a trigger-select register. The trigger-select register accepts only the bits that a fixed write mask allows. Pending requests that are not masked go through a rotating priority resolver. They are compared with the highest in-service input, and the winner drives a registered interrupt output.

Software programs the channel over a byte-wide, two-address register port. A write to address 0 with bit 4 set starts a setup sequence. Further address-1 words then load the vector base and, optionally, a mode word that selects nested handling of the cascade input and automatic end of interrupt. After setup, address-1 writes load the mask. Address-0 writes carry either a read/poll control word or an end-of-interrupt/rotation command. An acknowledge strobe returns the vector of the winning input and updates the in-service state. A poll read returns the winning input number instead and clears it.

Top module: `pic_channel`

## Requirements
- R1: An input whose trigger-select bit is 1 is in level mode: its request bit takes the sampled line value every cycle, and acknowledge does not clear it.
- R2: An input whose trigger-select bit is 0 is in edge mode: its request bit sets only when the line is sampled high after being sampled low, and it stays clear after acknowledge while the line is held high.
- R3: A write with `trig_sel` high stores the data ANDed with parameter `TRIG_WMASK` (default 0xF8) into the trigger-select register, and a read with `trig_sel` high returns that register. Setup does not clear it.
- R4: An address-0 write with bit 4 set clears the request, mask, in-service, rotation, base and mode state and forces `int_out` low on the next edge. Bit 0 of that word requests a fourth word. The next address-1 write sets the base from bits 7:3, and the one after is consumed. If a fourth word was requested, the following write sets nested mode from bit 4 and automatic end of interrupt from bit 1.
- R5: After setup, an address-1 write loads the mask, and a read of address 1 returns it. A masked request never asserts `int_out`.
- R6: Priority starts at input `offset` and runs upward modulo 8. A pending request wins only if it ranks strictly above the highest in-service input. `int_out` shows the winner one cycle after the state that produced it.
- R7: In nested mode, the in-service bit of input `CASCADE_IDX` (default 2) does not block other requests. With special mask set (address-0 control word with bits 6 and 5 set), in-service bits whose mask bit is set do not block.
- R8: Acknowledge returns `{base, n}` on `ack_vec`, where n is the winner, or 7 when there is none. Without automatic end of interrupt it sets in-service bit n. With it, the in-service bit stays clear, and if rotate-on-auto-end is set, `offset` becomes n+1.
- R9: Command code 1 (address-0 bits 7:5, with bits 4:3 zero) clears the highest-priority in-service bit. Code 5 also sets `offset` to that input plus 1.
- R10: Code 3 clears the in-service bit named by bits 2:0. Code 7 also sets `offset` to that input plus 1. Code 6 sets `offset` to bits 2:0 plus 1. Codes 0 and 4 set rotate-on-auto-end from bit 7. Code 2 changes nothing.
- R11: An address-0 write with bit 3 set and bit 4 clear is a read control word. When its bit 1 is set, bit 0 selects whether address-0 reads return the in-service register (1) or the request register (0).
- R12: A control word with bit 2 set arms poll. The next address-0 or address-1 read returns the winning input number (7 if none), clears that input's in-service and edge request bits, and disarms poll, so the following read is an ordinary register read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, sampled every cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register address (0 or 1) |
| trig_sel | input | 1 | Selects the trigger-select register for this access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_vec | output | 8 | Registered vector returned by the last acknowledge |
| int_out | output | 1 | Registered interrupt request to the processor |

## Verification
The bench sweeps every request pattern under every rotation offset through poll reads. A resolver that rotated the wrong way, or that lost the wrap past input 7, would return the wrong input number. Directed cases check that a pending request is blocked by an equal or higher in-service input and preempts a lower one; an off-by-one compare would assert the output early. Nested mode and special mask are checked: a design that ignored them would keep `int_out` low while a legal request waits. Other cases cover spurious acknowledge (base plus 7), a held edge line that must not retrigger, and a level line that must survive acknowledge.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [1:0] {
    SETUP_IDLE  = 2'd0,
    SETUP_BASE  = 2'd1,
    SETUP_SKIP  = 2'd2,
    SETUP_MODE  = 2'd3
  } setup_st_e;

  localparam logic [2:0] OPC_ROT_CLR  = 3'd0;
  localparam logic [2:0] OPC_EOI      = 3'd1;
  localparam logic [2:0] OPC_EOI_AT   = 3'd3;
  localparam logic [2:0] OPC_ROT_SET  = 3'd4;
  localparam logic [2:0] OPC_EOI_ROT  = 3'd5;
  localparam logic [2:0] OPC_PRIO_AT  = 3'd6;
  localparam logic [2:0] OPC_EOI_ROTAT = 3'd7;

endpackage

// File: rtl/pic_prio_resolve.sv
// Rotating priority search: level k means input (k + start) mod W.
module pic_prio_resolve #(
  parameter int W    = 8,
  parameter int IW   = $clog2(W)
) (
  input  logic [W-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] level,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = |req;
    level = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (req[(k + int'(start)) % W]) level = k[IW-1:0];
    end
    idx = level + start;
  end

endmodule

// File: rtl/pic_req_latch.sv
// Per-input request capture with edge or level triggering.
module pic_req_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wipe,
  input  logic [W-1:0] lines,
  input  logic [W-1:0] level_mode,
  input  logic [W-1:0] clr,
  output logic [W-1:0] req
);

  logic [W-1:0] seen_q;
  logic [W-1:0] req_nxt;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (level_mode[i]) req_nxt[i] = lines[i];
      else req_nxt[i] = (req[i] & ~clr[i]) | (lines[i] & ~seen_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      req    <= '0;
      seen_q <= '0;
    end else begin
      req    <= req_nxt;
      seen_q <= lines;
    end
  end

endmodule

// File: rtl/pic_channel.sv
module pic_channel
  import pic_pkg::*;
#(
  parameter int          IRQ_W        = 8,
  parameter logic [7:0]  TRIG_WMASK   = 8'hF8,
  parameter bit          NEST_SKIP_EN = 1'b1,
  parameter int          CASCADE_IDX  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] irq_in,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic             trig_sel,
  input  logic [IRQ_W-1:0] bus_wdata,
  output logic [IRQ_W-1:0] bus_rdata,
  input  logic             ack,
  output logic [IRQ_W-1:0] ack_vec,
  output logic             int_out
);

  localparam int IDX_W  = $clog2(IRQ_W);
  localparam int BASE_W = IRQ_W - IDX_W;
  localparam logic [IRQ_W-1:0] ONE_HOT0 = {{(IRQ_W-1){1'b0}}, 1'b1};
  localparam logic [IRQ_W-1:0] CASC_BIT = ONE_HOT0 << CASCADE_IDX;

  // architectural state
  logic [IRQ_W-1:0]  irr;
  logic [IRQ_W-1:0]  imr_q;
  logic [IRQ_W-1:0]  isr_q;
  logic [IRQ_W-1:0]  trig_q;
  logic [IDX_W-1:0]  offset_q;
  logic [BASE_W-1:0] base_q;
  setup_st_e         setup_q;
  logic              want_mode_q;
  logic              nested_q;
  logic              aeoi_q;
  logic              rot_aeoi_q;
  logic              rsel_isr_q;
  logic              poll_q;
  logic              smask_q;

  // access decode
  logic             wr_ctl, wr_dat, wr_setup, wr_rdctl, wr_op, rd_ctl, rd_poll;
  logic [2:0]       opc;
  logic [IDX_W-1:0] tgt;

  assign wr_ctl   = bus_wr & ~trig_sel & ~bus_addr;
  assign wr_dat   = bus_wr & ~trig_sel &  bus_addr;
  assign wr_setup = wr_ctl &  bus_wdata[4];
  assign wr_rdctl = wr_ctl & ~bus_wdata[4] &  bus_wdata[3];
  assign wr_op    = wr_ctl & ~bus_wdata[4] & ~bus_wdata[3];
  assign rd_ctl   = bus_rd & ~trig_sel;
  assign rd_poll  = rd_ctl & poll_q;
  assign opc      = bus_wdata[7:5];
  assign tgt      = bus_wdata[IDX_W-1:0];

  // priority resolution
  logic [IRQ_W-1:0] pend_vec, block_vec, skip_vec;
  logic             pend_found, block_found, eoi_found, win;
  logic [IDX_W-1:0] pend_lvl, pend_idx, block_lvl, block_idx, eoi_lvl, eoi_idx;

  assign skip_vec  = ((NEST_SKIP_EN && nested_q) ? CASC_BIT : '0)
                   | (smask_q ? imr_q : '0);
  assign pend_vec  = irr & ~imr_q;
  assign block_vec = isr_q & ~skip_vec;

  pic_prio_resolve #(.W(IRQ_W)) u_pend (
    .req(pend_vec), .start(offset_q),
    .found(pend_found), .level(pend_lvl), .idx(pend_idx)
  );

  pic_prio_resolve #(.W(IRQ_W)) u_block (
    .req(block_vec), .start(offset_q),
    .found(block_found), .level(block_lvl), .idx(block_idx)
  );

  pic_prio_resolve #(.W(IRQ_W)) u_eoi (
    .req(isr_q), .start(offset_q),
    .found(eoi_found), .level(eoi_lvl), .idx(eoi_idx)
  );

  assign win = pend_found & (~block_found | (pend_lvl < block_lvl));

  logic [IRQ_W-1:0] win_bit, req_clr;
  assign win_bit = ONE_HOT0 << pend_idx;
  assign req_clr = (win & (ack | rd_poll)) ? win_bit : '0;

  pic_req_latch #(.W(IRQ_W)) u_latch (
    .clk(clk), .rst(rst), .wipe(wr_setup),
    .lines(irq_in), .level_mode(trig_q), .clr(req_clr), .req(irr)
  );

  // register updates
  always_ff @(posedge clk) begin
    if (rst) begin
      imr_q       <= '0;
      isr_q       <= '0;
      trig_q      <= '0;
      offset_q    <= '0;
      base_q      <= '0;
      setup_q     <= SETUP_IDLE;
      want_mode_q <= 1'b0;
      nested_q    <= 1'b0;
      aeoi_q      <= 1'b0;
      rot_aeoi_q  <= 1'b0;
      rsel_isr_q  <= 1'b0;
      poll_q      <= 1'b0;
      smask_q     <= 1'b0;
      bus_rdata   <= '0;
      ack_vec     <= '0;
      int_out     <= 1'b0;
    end else begin
      int_out <= win & ~wr_setup;

      if (bus_wr && trig_sel) trig_q <= bus_wdata & TRIG_WMASK[IRQ_W-1:0];

      if (wr_setup) begin
        imr_q       <= '0;
        isr_q       <= '0;
        offset_q    <= '0;
        base_q      <= '0;
        nested_q    <= 1'b0;
        aeoi_q      <= 1'b0;
        rot_aeoi_q  <= 1'b0;
        rsel_isr_q  <= 1'b0;
        poll_q      <= 1'b0;
        smask_q     <= 1'b0;
        setup_q     <= SETUP_BASE;
        want_mode_q <= bus_wdata[0];
      end else if (wr_rdctl) begin
        if (bus_wdata[2]) poll_q <= 1'b1;
        if (bus_wdata[1]) rsel_isr_q <= bus_wdata[0];
        if (bus_wdata[6]) smask_q <= bus_wdata[5];
      end else if (wr_op) begin
        case (opc)
          OPC_ROT_CLR, OPC_ROT_SET: rot_aeoi_q <= bus_wdata[7];
          OPC_EOI: begin
            if (eoi_found) isr_q[eoi_idx] <= 1'b0;
          end
          OPC_EOI_ROT: begin
            if (eoi_found) begin
              isr_q[eoi_idx] <= 1'b0;
              offset_q       <= eoi_idx + 1'b1;
            end
          end
          OPC_EOI_AT: isr_q[tgt] <= 1'b0;
          OPC_PRIO_AT: offset_q <= tgt + 1'b1;
          OPC_EOI_ROTAT: begin
            isr_q[tgt] <= 1'b0;
            offset_q   <= tgt + 1'b1;
          end
          default: ;
        endcase
      end else if (wr_dat) begin
        case (setup_q)
          SETUP_IDLE: imr_q <= bus_wdata;
          SETUP_BASE: begin
            base_q  <= bus_wdata[IRQ_W-1:IDX_W];
            setup_q <= SETUP_SKIP;
          end
          SETUP_SKIP: setup_q <= want_mode_q ? SETUP_MODE : SETUP_IDLE;
          SETUP_MODE: begin
            nested_q <= bus_wdata[4];
            aeoi_q   <= bus_wdata[1];
            setup_q  <= SETUP_IDLE;
          end
          default: setup_q <= SETUP_IDLE;
        endcase
      end

      if (ack) begin
        ack_vec <= {base_q, (win ? pend_idx : {IDX_W{1'b1}})};
        if (win) begin
          if (aeoi_q) begin
            if (rot_aeoi_q) offset_q <= pend_idx + 1'b1;
          end else begin
            isr_q[pend_idx] <= 1'b1;
          end
        end
      end

      if (rd_ctl) begin
        if (poll_q) begin
          bus_rdata <= {{BASE_W{1'b0}}, (win ? pend_idx : {IDX_W{1'b1}})};
          if (win) isr_q[pend_idx] <= 1'b0;
          poll_q <= 1'b0;
        end else if (bus_addr) begin
          bus_rdata <= imr_q;
        end else begin
          bus_rdata <= rsel_isr_q ? isr_q : irr;
        end
      end else if (bus_rd && trig_sel) begin
        bus_rdata <= trig_q;
      end
    end
  end

endmodule

// File: rtl/pic_channel_chk.sv
module pic_channel_chk #(
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [IRQ_W-1:0] irq_in,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_addr,
  input logic             trig_sel,
  input logic [IRQ_W-1:0] bus_wdata,
  input logic             ack,
  input logic             int_out,
  input logic [IRQ_W-1:0] irr,
  input logic [IRQ_W-1:0] imr_q,
  input logic [IRQ_W-1:0] isr_q,
  input logic [IRQ_W-1:0] trig_q,
  input logic             aeoi_q,
  input logic             poll_q
);

  logic setup_wr;
  assign setup_wr = bus_wr && !trig_sel && !bus_addr && bus_wdata[4];

  assert_level_follow_R1: assert property (@(posedge clk) disable iff (rst)
    !setup_wr |=> (((irr ^ $past(irq_in)) & $past(trig_q)) == '0));

  assert_edge_needs_line_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irr & ~$past(irr) & ~$past(trig_q) & ~$past(irq_in)) == '0));

  assert_trig_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && trig_sel) |=> $stable(trig_q));

  assert_int_drop_setup_R4: assert property (@(posedge clk) disable iff (rst)
    setup_wr |=> !int_out);

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && !trig_sel) |=> $stable(imr_q));

  assert_int_has_req_R6: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past((irr & ~imr_q) != '0));

  assert_aeoi_no_isr_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && aeoi_q && !bus_wr && !bus_rd) |=> ((isr_q & ~$past(isr_q)) == '0));

  assert_poll_once_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !trig_sel && poll_q && !bus_wr) |=> !poll_q);

endmodule

bind pic_channel pic_channel_chk #(.IRQ_W(IRQ_W)) chk_i (
  .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .trig_sel(trig_sel), .bus_wdata(bus_wdata), .ack(ack),
  .int_out(int_out), .irr(irr), .imr_q(imr_q), .isr_q(isr_q), .trig_q(trig_q),
  .aeoi_q(aeoi_q), .poll_q(poll_q)
);

// File: tb/pic_channel_tb_top.sv
module pic_channel_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0, trig_sel = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ack = 1'b0;
  logic [7:0] ack_vec;
  logic       int_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pic_channel dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .trig_sel(trig_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack(ack), .ack_vec(ack_vec), .int_out(int_out)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; trig_sel = 1'b0; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_trig(input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; trig_sel = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; trig_sel = 1'b0;
  endtask

  task automatic rd(input logic a, input logic sel, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; trig_sel = sel;
    @(negedge clk);
    bus_rd = 1'b0; trig_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    v = ack_vec;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] base, input logic four, input logic [7:0] mode);
    wr(1'b0, 8'h10 | {7'd0, four});
    wr(1'b1, base);
    wr(1'b1, 8'h00);
    if (four) wr(1'b1, mode);
  endtask

  function automatic logic [7:0] poll_model(input logic [7:0] pat, input int off);
    for (int k = 0; k < 8; k++) begin
      if (pat[(off + k) % 8]) return 8'((off + k) % 8);
    end
    return 8'd7;
  endfunction

  logic [7:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    check("R4 reset int_out", {7'd0, int_out}, 8'h00);
    rd(1'b1, 1'b0, r); check("R5 reset mask", r, 8'h00);
    rd(1'b0, 1'b0, r); check("R11 reset request", r, 8'h00);

    // R3 trigger-select write mask
    wr_trig(8'hFF); rd(1'b0, 1'b1, r); check("R3 trig masked", r, 8'hF8);
    wr_trig(8'h00); rd(1'b0, 1'b1, r); check("R3 trig cleared", r, 8'h00);

    // R4/R5 setup with fourth word, masking
    setup(8'h20, 1'b1, 8'h00);
    wr(1'b1, 8'hFF);
    set_irq(8'h01);
    check("R5 masked no int", {7'd0, int_out}, 8'h00);
    rd(1'b1, 1'b0, r); check("R5 mask readback", r, 8'hFF);
    wr(1'b1, 8'h00); settle();
    check("R5 unmasked int", {7'd0, int_out}, 8'h01);

    // R8 acknowledge, R2 no retrigger while held
    do_ack(r); check("R8 ack vector", r, 8'h20);
    wr(1'b0, 8'h0A); rd(1'b0, 1'b0, r); check("R2 held edge cleared", r, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, 1'b0, r); check("R11 isr select", r, 8'h01);
    settle(); check("R6 self blocked", {7'd0, int_out}, 8'h00);

    // R6 nesting, R9 non-specific EOI
    set_irq(8'h09);
    check("R6 lower blocked", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h20); settle();
    check("R9 eoi unblocks", {7'd0, int_out}, 8'h01);
    do_ack(r); check("R8 ack input3", r, 8'h23);
    rd(1'b0, 1'b0, r); check("R8 isr set", r, 8'h08);
    set_irq(8'h0B);
    check("R6 higher preempts", {7'd0, int_out}, 8'h01);
    do_ack(r); check("R8 ack input1", r, 8'h21);
    wr(1'b0, 8'h20); rd(1'b0, 1'b0, r); check("R9 eoi highest only", r, 8'h08);
    wr(1'b0, 8'h63); rd(1'b0, 1'b0, r); check("R10 specific eoi", r, 8'h00);

    // R10 code 2 no-op, code 7
    set_irq(8'h00); set_irq(8'h10);
    do_ack(r); check("R8 ack input4", r, 8'h24);
    wr(1'b0, 8'h40); rd(1'b0, 1'b0, r); check("R10 code2 no effect", r, 8'h10);
    wr(1'b0, 8'hE4); rd(1'b0, 1'b0, r); check("R10 code7 clears", r, 8'h00);
    set_irq(8'h00); set_irq(8'h21);
    wr(1'b0, 8'h0E);
    rd(1'b0, 1'b0, r); check("R12 poll after code7 rotation", r, 8'h05);
    rd(1'b0, 1'b0, r); check("R12 poll disarmed", r, 8'h01);

    // R9 code 5
    do_ack(r); check("R8 ack wraps", r, 8'h20);
    wr(1'b0, 8'hA0);
    set_irq(8'h00); set_irq(8'h03);
    wr(1'b0, 8'h0C); rd(1'b0, 1'b0, r); check("R9 code5 rotation", r, 8'h01);

    // R10 code 6
    wr(1'b0, 8'hC5);
    set_irq(8'h00); set_irq(8'h41);
    wr(1'b0, 8'h0C); rd(1'b0, 1'b0, r); check("R10 code6 rotation", r, 8'h06);

    // R12 empty poll, R8 spurious
    set_irq(8'h00);
    setup(8'h20, 1'b0, 8'h00);
    wr(1'b0, 8'h0C); rd(1'b0, 1'b0, r); check("R12 poll none", r, 8'h07);
    rd(1'b0, 1'b0, r); check("R12 plain read after poll", r, 8'h00);
    do_ack(r); check("R8 spurious vector", r, 8'h27);

    // R8 automatic end of interrupt and rotation
    setup(8'h20, 1'b1, 8'h02);
    set_irq(8'h01);
    do_ack(r); check("R8 aeoi vector", r, 8'h20);
    wr(1'b0, 8'h0B); rd(1'b0, 1'b0, r); check("R8 aeoi isr clear", r, 8'h00);
    wr(1'b0, 8'h80);
    set_irq(8'h00); set_irq(8'h01);
    do_ack(r); check("R10 rot flag ack", r, 8'h20);
    set_irq(8'h00); set_irq(8'h03);
    do_ack(r); check("R8 rotate on aeoi", r, 8'h21);

    // R7 nested mode, R4 output drop
    set_irq(8'h00);
    setup(8'h20, 1'b1, 8'h10);
    set_irq(8'h04);
    do_ack(r); check("R8 ack cascade input", r, 8'h22);
    set_irq(8'h24);
    check("R7 nested skips cascade", {7'd0, int_out}, 8'h01);
    set_irq(8'h00);
    check("R4 int before setup", {7'd0, int_out}, 8'h01);
    wr(1'b0, 8'h11);
    check("R4 setup drops int", {7'd0, int_out}, 8'h00);
    wr(1'b1, 8'h20); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    set_irq(8'h04);
    do_ack(r);
    set_irq(8'h24);
    check("R7 not nested blocks", {7'd0, int_out}, 8'h00);

    // R7 special mask
    set_irq(8'h00);
    setup(8'h20, 1'b0, 8'h00);
    set_irq(8'h02);
    do_ack(r); check("R8 ack input1 again", r, 8'h21);
    wr(1'b1, 8'h02);
    set_irq(8'h22);
    check("R7 blocked without special mask", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h68); settle();
    check("R7 special mask unblocks", {7'd0, int_out}, 8'h01);

    // R1 level mode
    set_irq(8'h00);
    wr_trig(8'h08);
    setup(8'h20, 1'b0, 8'h00);
    set_irq(8'h08);
    rd(1'b0, 1'b0, r); check("R1 level request", r, 8'h08);
    do_ack(r); check("R1 level ack vector", r, 8'h23);
    rd(1'b0, 1'b0, r); check("R1 level survives ack", r, 8'h08);
    set_irq(8'h00);
    rd(1'b0, 1'b0, r); check("R1 level follows low", r, 8'h00);
    wr_trig(8'h00);

    // R6 sweep: every pattern under every offset
    for (int off = 0; off < 8; off++) begin
      for (int pat = 0; pat < 256; pat++) begin
        set_irq(8'h00);
        setup(8'h08, 1'b0, 8'h00);
        wr(1'b0, 8'hC0 | 8'((off + 7) % 8));
        set_irq(8'(pat));
        check("R6 sweep int_out", {7'd0, int_out}, (pat != 0) ? 8'h01 : 8'h00);
        wr(1'b0, 8'h0C);
        rd(1'b0, 1'b0, r);
        check("R6 sweep winner", r, poll_model(8'(pat), off));
      end
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule